// File: doc/BRIEF.md
# FSK Tone Demodulator for On-Hook Caller Data

This block turns a stream of signed, band-limited line samples into a serial data line for on-hook caller identification. Each sample arrives with a one-cycle valid strobe at 9600 samples/s, which is eight samples per 1200 bit/s data bit. Two tone pairs are supported, chosen by a mode input. In Bell 202 mode, mark (logic 1) is 1200 Hz and space (logic 0) is 2200 Hz. In V.23 mode 2, mark is 1300 Hz and space is 2100 Hz. The transmitter is phase-continuous, so the tone changes at bit boundaries without a phase step.

For every accepted sample, four correlators update a sliding one-bit window: an in-phase and a quadrature arm for the mark tone, and the same pair for the space tone. The mark and space energy estimates are compared to give one raw decision per sample. A vote over the three most recent decisions removes single-sample glitches. The result then goes to a registered output. While the enable input is low (the receiver is not fully powered up), the output is held at logic 1. The downstream byte framer treats that level as idle marking.

Top module: `fsk_tone_demod`

## Requirements
- R1: While reset is high, and after it falls until samples change it, `data_out` is 1.
- R2: With `mode_sel`=0, a steady 1200 Hz tone gives `data_out`=1 from the tenth sample of the run onward.
- R3: With `mode_sel`=0, a steady 2200 Hz tone gives `data_out`=0 from the tenth sample of the run onward.
- R4: With `mode_sel`=1, a steady 1300 Hz tone gives 1 and a steady 2100 Hz tone gives 0, each from the tenth sample of the run.
- R5: With `mode_sel`=0, mark tones at 1200 Hz ±12 Hz decode as 1 and space tones at 2200 Hz ±22 Hz decode as 0.
- R6: A phase-continuous data stream whose level holds for at least two bit times is reproduced on `data_out` by the last six samples of each held level, in both modes. The window energy never exceeds its full-scale bound.
- R7: `data_out` changes only within the two clock cycles after a clock edge that accepts a sample, after a mode change, or after `enable` changes. It is stable in between.
- R8: When `enable` is low, `data_out` is 1 from the next clock edge, whatever the line carries. When `enable` returns high, the decoded value appears at the next clock edge.
- R9: A change of `mode_sel` empties the correlation windows. `data_out` (when enabled) is 1 for the first eight samples after the change, and then follows the new tone pair.
- R10: Decoding does not depend on the tone amplitude (64 to 2040 counts) or on the starting phase of the tone.
- R11: Samples presented while `smp_valid` is low are ignored. The decoded level and later decisions are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Full power-up; when low the output is forced to 1 |
| mode_sel | input | 1 | Tone pair: 0 = 1200/2200 Hz, 1 = 1300/2100 Hz |
| smp_valid | input | 1 | One-cycle strobe qualifying `smp_data` |
| smp_data | input | SMP_W (12) | Signed two's-complement line sample |
| data_out | output | 1 | Demodulated serial data, 1 = mark |

## Verification
The bench builds the block with its default parameters: 12-bit samples, an eight-sample window, a 16-bit phase accumulator and a 9600 Hz sample rate. Because the window is only eight samples, a tone run of twenty samples fills it completely. This makes a sweep practical over both modes, both tones, four amplitudes and three starting phases. The expected level for each sample is derived from the tone that was sent. The same small window also makes the eight-sample flush after a mode change directly observable.

// File: rtl/fskd_pkg.sv
package fskd_pkg;

  // Width of the reference sine values.
  localparam int REF_W = 8;

  // Sixteen-step sine reference, amplitude 127.
  function automatic logic signed [REF_W-1:0] ref_sin(input logic [3:0] idx);
    logic [6:0] m;
    case (idx[2:0])
      3'd0:       m = 7'd0;
      3'd1, 3'd7: m = 7'd49;
      3'd2, 3'd6: m = 7'd90;
      3'd3, 3'd5: m = 7'd117;
      default:    m = 7'd127;
    endcase
    return idx[3] ? -$signed({1'b0, m}) : $signed({1'b0, m});
  endfunction

  // Phase increment per sample for a tone, rounded to nearest.
  function automatic int phase_step(input int f_hz, input int fs_hz, input int pw);
    longint num;
    num = (longint'(f_hz) << pw) + longint'(fs_hz / 2);
    return int'(num / longint'(fs_hz));
  endfunction

endpackage

// File: rtl/fskd_corr.sv
// One tone correlator: a local oscillator plus sine and cosine arms, each
// summed over a sliding window of WIN samples.
module fskd_corr import fskd_pkg::*; #(
  parameter int SMP_W   = 12,
  parameter int WIN     = 8,
  parameter int PHASE_W = 16,
  parameter int ACC_W   = 23,
  parameter int INC_0   = 8192,
  parameter int INC_1   = 8875
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    sel,
  input  logic                    push,
  input  logic                    full,
  input  logic signed [SMP_W-1:0] smp,
  output logic [ACC_W:0]          mag
);

  localparam int PROD_W = SMP_W + REF_W;
  localparam int AW     = (WIN > 1) ? $clog2(WIN) : 1;
  localparam longint LIMIT = longint'(WIN) * (longint'(1) << (SMP_W - 1)) * 127;

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] step;
  logic [3:0]         idx;
  logic [AW-1:0]      wptr;
  logic [ACC_W-1:0]   absv [2];

  assign step = sel ? PHASE_W'(INC_1) : PHASE_W'(INC_0);
  assign idx  = phase[PHASE_W-1 -: 4];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase <= '0;
      wptr  <= '0;
    end else if (push) begin
      phase <= phase + step;
      wptr  <= (wptr == AW'(WIN - 1)) ? '0 : wptr + 1'b1;
    end
  end

  genvar q;
  generate
    for (q = 0; q < 2; q++) begin : g_arm
      logic signed [REF_W-1:0]  refv;
      logic signed [PROD_W-1:0] prod;
      logic signed [PROD_W-1:0] old;
      logic signed [ACC_W-1:0]  acc;
      logic signed [PROD_W-1:0] hist [WIN];

      assign refv = ref_sin(idx + 4'(q * 4));
      assign prod = PROD_W'(smp) * PROD_W'(refv);

      // Window storage: one write port, one read port, no reset.
      always_ff @(posedge clk) begin
        if (push) hist[wptr] <= prod;
      end

      assign old = full ? hist[wptr] : '0;

      always_ff @(posedge clk) begin
        if (rst || clr)  acc <= '0;
        else if (push)   acc <= acc + ACC_W'(prod) - ACC_W'(old);
      end

      assign absv[q] = acc[ACC_W-1] ? $unsigned(-acc) : $unsigned(acc);

      // R6: the window sum stays within the full-scale bound.
      assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        longint'(absv[q]) <= LIMIT)
        else $error("window energy beyond bound");
    end
  endgenerate

  assign mag = {1'b0, absv[0]} + {1'b0, absv[1]};

endmodule

// File: rtl/fskd_vote.sv
// Majority vote over the last N raw decisions; history clears to all marks.
module fskd_vote #(
  parameter int N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic stb,
  input  logic bit_in,
  output logic vote
);

  logic [N-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst || clr)  hist <= '1;
    else if (stb)    hist <= {hist[N-2:0], bit_in};
  end

  assign vote = ($countones(hist) > (N / 2));

  // R7: the vote moves only after a decision strobe or a clear.
  assert_vote_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(stb || clr) |=> $stable(vote))
    else $error("vote changed without a decision");

endmodule

// File: rtl/fsk_tone_demod.sv
module fsk_tone_demod import fskd_pkg::*; #(
  parameter int SMP_W      = 12,
  parameter int WIN        = 8,
  parameter int PHASE_W    = 16,
  parameter int SAMPLE_HZ  = 9600,
  parameter int MARK_A_HZ  = 1200,
  parameter int SPACE_A_HZ = 2200,
  parameter int MARK_B_HZ  = 1300,
  parameter int SPACE_B_HZ = 2100,
  parameter int VOTE_N     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    mode_sel,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  output logic                    data_out
);

  localparam int ACC_W  = SMP_W + REF_W + $clog2(WIN) + 1;
  localparam int FILL_W = $clog2(WIN + 1);
  localparam int INC_MA = phase_step(MARK_A_HZ,  SAMPLE_HZ, PHASE_W);
  localparam int INC_SA = phase_step(SPACE_A_HZ, SAMPLE_HZ, PHASE_W);
  localparam int INC_MB = phase_step(MARK_B_HZ,  SAMPLE_HZ, PHASE_W);
  localparam int INC_SB = phase_step(SPACE_B_HZ, SAMPLE_HZ, PHASE_W);

  logic              mode_q;
  logic              mode_chg;
  logic              accept;
  logic [FILL_W-1:0] fill;
  logic              win_full;
  logic              dec_stb;
  logic              raw;
  logic              vote;
  logic [ACC_W:0]    mag [2];

  assign mode_chg = (mode_sel != mode_q);
  assign accept   = smp_valid && !mode_chg;
  assign win_full = (fill == FILL_W'(WIN));

  always_ff @(posedge clk) mode_q <= mode_sel;

  always_ff @(posedge clk) begin
    if (rst || mode_chg) begin
      fill    <= '0;
      dec_stb <= 1'b0;
    end else begin
      dec_stb <= accept;
      if (accept && !win_full) fill <= fill + 1'b1;
    end
  end

  // Tone 0 = mark, tone 1 = space.
  genvar t;
  generate
    for (t = 0; t < 2; t++) begin : g_tone
      fskd_corr #(
        .SMP_W(SMP_W), .WIN(WIN), .PHASE_W(PHASE_W), .ACC_W(ACC_W),
        .INC_0((t == 0) ? INC_MA : INC_SA),
        .INC_1((t == 0) ? INC_MB : INC_SB)
      ) i_corr (
        .clk(clk), .rst(rst), .clr(mode_chg), .sel(mode_sel),
        .push(accept), .full(win_full), .smp(smp_data), .mag(mag[t])
      );
    end
  endgenerate

  // Mark until the window holds a full bit; ties favour mark.
  assign raw = !win_full || (mag[0] >= mag[1]);

  fskd_vote #(.N(VOTE_N)) i_vote (
    .clk(clk), .rst(rst), .clr(mode_chg), .stb(dec_stb),
    .bit_in(raw), .vote(vote)
  );

  always_ff @(posedge clk) begin
    if (rst) data_out <= 1'b1;
    else     data_out <= enable ? vote : 1'b1;
  end

  // R8: disabled receiver drives idle marking.
  assert_idle_high_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> data_out)
    else $error("output not idle while disabled");

  // R9: a mode change flushes to mark.
  assert_mode_flush_R9: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> ##1 data_out)
    else $error("output not mark after mode change");

  // R9: fill count never passes the window length.
  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (rst)
    fill <= FILL_W'(WIN))
    else $error("fill count out of range");

endmodule

// File: tb/test_fsk_tone_demod.sv
module test_fsk_tone_demod;

  localparam real TWO_PI = 6.283185307179586;
  localparam real FS     = 9600.0;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst;
  logic               enable;
  logic               mode_sel;
  logic               smp_valid;
  logic signed [11:0] smp_data;
  logic               data_out;

  fsk_tone_demod i_fsk_tone_demod (
    .clk(clk), .rst(rst), .enable(enable), .mode_sel(mode_sel),
    .smp_valid(smp_valid), .smp_data(smp_data), .data_out(data_out)
  );

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;
  real  ph    = 0.0;
  logic out_a, out_b;

  task automatic check(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got=%0b expected=%0b", tag, got, exp);
    end
  endtask

  // Drive one strobed sample, then read the output twice before the next one.
  task automatic push(input int x);
    @(negedge clk);
    smp_data  = 12'(x);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    out_a = data_out;
    repeat (3) @(negedge clk);
    out_b = data_out;
  endtask

  // Phase-continuous tone; checks the level on samples index >= from.
  task automatic tone(input real f, input int n, input real amp, input int from,
                      input logic exp, input string tag);
    for (int i = 0; i < n; i++) begin
      real v;
      int  x;
      v = amp * $sin(ph);
      x = (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
      if (x > 2047) x = 2047;
      if (x < -2048) x = -2048;
      ph = ph + TWO_PI * f / FS;
      if (ph > TWO_PI) ph = ph - TWO_PI;
      push(x);
      check(out_b, out_a, "R7 stable between samples");
      if (i >= from) check(out_a, exp, tag);
    end
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    mode_sel = m;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    real amps [4];
    real phs  [3];
    int  pat  [8];
    amps = '{64.0, 500.0, 1500.0, 2040.0};
    phs  = '{0.0, 1.3, 3.9};
    pat  = '{1, 0, 0, 1, 1, 0, 1, 0};

    rst = 1'b1; enable = 1'b1; mode_sel = 1'b0; smp_valid = 1'b0; smp_data = '0;
    repeat (4) @(negedge clk);
    check(data_out, 1'b1, "R1 during reset");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(data_out, 1'b1, "R1 after reset");

    // R2 R3 R4 R10: sweep modes, tones, amplitudes and phases.
    for (int m = 0; m < 2; m++) begin
      set_mode(m[0]);
      for (int a = 0; a < 4; a++) begin
        for (int p = 0; p < 3; p++) begin
          ph = phs[p];
          tone(m ? 1300.0 : 1200.0, 20, amps[a], 10, 1'b1,
               m ? "R4 R10 mark" : "R2 R10 mark");
          ph = phs[p] + 0.7;
          tone(m ? 2100.0 : 2200.0, 20, amps[a], 10, 1'b0,
               m ? "R4 R10 space" : "R3 R10 space");
        end
      end
    end

    // R5: frequency tolerance in the 1200/2200 pair.
    set_mode(1'b0);
    tone(1188.0, 20, 1000.0, 10, 1'b1, "R5 mark low");
    tone(2222.0, 20, 1000.0, 10, 1'b0, "R5 space high");
    tone(1212.0, 20, 1000.0, 10, 1'b1, "R5 mark high");
    tone(2178.0, 20, 1000.0, 10, 1'b0, "R5 space low");

    // R6: phase-continuous data, levels held two bit times.
    for (int m = 0; m < 2; m++) begin
      set_mode(m[0]);
      for (int b = 0; b < 8; b++) begin
        if (pat[b] == 1) tone(m ? 1300.0 : 1200.0, 16, 900.0, 10, 1'b1, "R6 data mark");
        else             tone(m ? 2100.0 : 2200.0, 16, 900.0, 10, 1'b0, "R6 data space");
      end
    end

    // R9: mode change flushes windows, mark for eight samples.
    set_mode(1'b0);
    tone(2200.0, 20, 1000.0, 10, 1'b0, "R9 space before change");
    set_mode(1'b1);
    tone(2100.0, 8, 1000.0, 0, 1'b1, "R9 flushed to mark");
    tone(2100.0, 12, 1000.0, 2, 1'b0, "R9 new pair decoded");

    // R8: disable forces idle marking, re-enable restores decoding.
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(data_out, 1'b1, "R8 forced high next edge");
    tone(2100.0, 6, 1000.0, 0, 1'b1, "R8 held high on space");
    enable = 1'b1;
    @(negedge clk);
    check(data_out, 1'b0, "R8 decoding resumed");

    // R11: samples without strobe are ignored.
    set_mode(1'b0);
    tone(1200.0, 20, 1000.0, 10, 1'b1, "R11 mark before");
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      smp_data = (i % 2 == 1) ? 12'sd2000 : -12'sd2000;
      check(data_out, 1'b1, "R11 no strobe");
    end
    tone(1200.0, 10, 1000.0, 0, 1'b1, "R11 window intact");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule